// File: doc/BRIEF.md
# Cascadable Offset Binary Counter

A synchronous up-counter, 4 bits wide by default, with synchronous clear, synchronous parallel load and a count enable. Each count advances the value by one. When the value reaches the all-ones state, the next count reloads a programmable start value instead of wrapping to zero. This gives a counter whose range begins at a chosen offset.

When end comparison is enabled, the counter also reloads the start value on the count after it reaches a programmable end value. It therefore runs over a closed range from start to end and repeats.

A carry output goes high while the counter holds all ones and is enabled. Feeding it to the enable of a second instance builds a wider counter, and that upper stage advances exactly once per lower-stage rollover.

Top module: `offset_counter`

## Requirements
- R1: While `rst_ni` is low, `q_o` is 0 (asynchronous reset).
- R2: `clr_i` high at a rising edge sets `q_o` to 0, overriding load and enable.
- R3: `load_i` high with `clr_i` low at a rising edge copies `data_i` to `q_o`, whatever `en_i` is.
- R4: With `clr_i`, `load_i` and `en_i` all low, `q_o` holds its value.
- R5: An enabled count with no reload condition adds one: bit i flips exactly when all bits below it are 1, and bit 0 always flips.
- R6: An enabled count from all ones (1111) loads `start_i`.
- R7: With `end_cmp_en_i` high, an enabled count from `q_o == end_i` loads `start_i`.
- R8: With `end_cmp_en_i` low, `end_i` has no effect and the count passes through the end value.
- R9: `rco_o` is high exactly when `en_i` is high and `q_o` is all ones; it is combinational.
- R10: Two instances joined by lower `rco_o` to upper `en_i`, both with start 0, form an 8-bit binary counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear |
| load_i | input | 1 | Synchronous parallel load |
| en_i | input | 1 | Count enable |
| data_i | input | W | Parallel load value |
| start_i | input | W | Value loaded on reload |
| end_i | input | W | Terminal value for end comparison |
| end_cmp_en_i | input | 1 | Enables end comparison |
| q_o | output | W | Count value |
| rco_o | output | 1 | Carry out for cascading |

## Verification
A wrong count state shows on `q_o` at the first rising edge after it forms, because the register drives the port directly. A wrong reload decision shows in the same cycle as a value other than `start_i` following 1111 or the end value. A broken carry appears in the cascade test as the upper stage drifting from the expected value, within 16 lower-stage counts. The directed tests walk each reload path with start and end values that differ from zero and from the all-ones state, so a reload to zero is told apart from a reload to start.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } oc_op_e;
endpackage

// File: rtl/oc_incr.sv
module oc_incr #(
  parameter int W = 4
) (
  input  logic [W-1:0] q_i,
  output logic [W-1:0] inc_o,
  output logic         all_ones_o
);
  logic [W:0] carry;
  assign carry[0] = 1'b1;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign carry[i+1] = carry[i] & q_i[i];
    assign inc_o[i]   = q_i[i] ^ carry[i];
  end
  assign all_ones_o = carry[W];
endmodule

// File: rtl/oc_term.sv
module oc_term #(
  parameter int W = 4
) (
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] end_i,
  input  logic         cmp_en_i,
  input  logic         all_ones_i,
  output logic         reload_o
);
  assign reload_o = all_ones_i | (cmp_en_i & (q_i == end_i));
endmodule

// File: rtl/oc_ctrl.sv
module oc_ctrl
  import oc_pkg::*;
(
  input  logic   clr_i,
  input  logic   load_i,
  input  logic   en_i,
  output oc_op_e op_o
);
  always_comb begin
    if (clr_i)       op_o = OP_CLEAR;
    else if (load_i) op_o = OP_LOAD;
    else if (en_i)   op_o = OP_COUNT;
    else             op_o = OP_HOLD;
  end
endmodule

// File: rtl/offset_counter.sv
module offset_counter
  import oc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic         en_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] start_i,
  input  logic [W-1:0] end_i,
  input  logic         end_cmp_en_i,
  output logic [W-1:0] q_o,
  output logic         rco_o
);
  logic [W-1:0] q_q, q_d, inc;
  logic         all_ones, reload;
  oc_op_e       op;

  oc_incr #(.W(W)) u_incr (.q_i(q_q), .inc_o(inc), .all_ones_o(all_ones));

  oc_term #(.W(W)) u_term (
    .q_i(q_q), .end_i(end_i), .cmp_en_i(end_cmp_en_i),
    .all_ones_i(all_ones), .reload_o(reload)
  );

  oc_ctrl u_ctrl (.clr_i(clr_i), .load_i(load_i), .en_i(en_i), .op_o(op));

  always_comb begin
    unique case (op)
      OP_CLEAR: q_d = '0;
      OP_LOAD:  q_d = data_i;
      OP_COUNT: q_d = reload ? start_i : inc;
      default:  q_d = q_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o   = q_q;
  // carry gated by enable so an upper stage steps once per rollover
  assign rco_o = en_i & all_ones;
endmodule

// File: rtl/oc_checker.sv
module oc_checker #(
  parameter int W = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         clr_i,
  input logic         load_i,
  input logic         en_i,
  input logic [W-1:0] data_i,
  input logic [W-1:0] start_i,
  input logic [W-1:0] end_i,
  input logic         end_cmp_en_i,
  input logic [W-1:0] q_o,
  input logic         rco_o
);
  localparam logic [W-1:0] ONES = {W{1'b1}};

  p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> q_o == '0);
  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && load_i) |=> q_o == $past(data_i));
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_i && !en_i) |=> $stable(q_o));
  p_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_i && en_i && q_o != ONES && !(end_cmp_en_i && q_o == end_i))
      |=> q_o == $past(q_o) + 1'b1);
  p_rco_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rco_o && !clr_i && !load_i) |=> q_o == $past(start_i));
  p_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_i && en_i && end_cmp_en_i && q_o == end_i)
      |=> q_o == $past(start_i));
  p_rco_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !rco_o);
endmodule

bind offset_counter oc_checker #(.W(W)) u_chk (.*);

// File: tb/offset_counter_bench.sv
`timescale 1ns/1ps
module offset_counter_bench;
  logic       clk = 0, rst_ni = 0;
  logic       clr = 0, load = 0, en = 0, cmp = 0;
  logic [3:0] data = 0, start = 0, endv = 0;
  logic [3:0] q, q_up;
  logic       rco, rco_up;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  offset_counter #(.W(4)) u_offset_counter (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr), .load_i(load), .en_i(en),
    .data_i(data), .start_i(start), .end_i(endv), .end_cmp_en_i(cmp),
    .q_o(q), .rco_o(rco));

  // R10 upper stage
  offset_counter #(.W(4)) u_upper (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr), .load_i(1'b0), .en_i(rco),
    .data_i(4'd0), .start_i(4'd0), .end_i(4'd0), .end_cmp_en_i(1'b0),
    .q_o(q_up), .rco_o(rco_up));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask

  task automatic do_load(input logic [3:0] v);
    clr = 0; en = 0; load = 1; data = v; tick(); load = 0;
  endtask

  task automatic t_reset;
    rst_ni = 0; tick();
    chk("R1 reset", {4'd0, q}, 8'd0);
    rst_ni = 1; tick();
    chk("R1 after release", {4'd0, q}, 8'd0);
  endtask

  task automatic t_clear;
    do_load(4'h9);
    clr = 1; load = 1; en = 1; data = 4'h5; tick();
    chk("R2 clear over load", {4'd0, q}, 8'd0);
    clr = 0; load = 0; en = 0;
  endtask

  task automatic t_load;
    load = 1; en = 1; data = 4'hA; tick();
    chk("R3 load over count", {4'd0, q}, 8'h0A);
    load = 0; en = 0;
  endtask

  task automatic t_hold;
    do_load(4'h7); cmp = 1; endv = 4'h7; start = 4'h2;
    tick(); tick();
    chk("R4 hold", {4'd0, q}, 8'h07);
    cmp = 0;
  endtask

  task automatic t_count;
    logic [3:0] e;
    do_load(4'h0); start = 4'h0; cmp = 0; en = 1;
    e = 0;
    for (int i = 0; i < 15; i++) begin
      tick(); e = e + 1;
      chk("R5 increment", {4'd0, q}, {4'd0, e});
    end
    en = 0;
  endtask

  task automatic t_wrap;
    start = 4'h6; cmp = 0; do_load(4'hE); en = 1;
    tick(); chk("R6 reach 1111", {4'd0, q}, 8'h0F);
    tick(); chk("R6 wrap to start", {4'd0, q}, 8'h06);
    tick(); chk("R6 after wrap", {4'd0, q}, 8'h07);
    en = 0;
  endtask

  task automatic t_end;
    logic [3:0] seq [6] = '{4'h4, 4'h5, 4'h3, 4'h4, 4'h5, 4'h3};
    start = 4'h3; endv = 4'h5; cmp = 1; do_load(4'h3); en = 1;
    for (int i = 0; i < 6; i++) begin
      tick(); chk("R7 start-end range", {4'd0, q}, {4'd0, seq[i]});
    end
    en = 0;
    start = 4'h0; endv = 4'hD; do_load(4'hC); en = 1;
    tick(); chk("R7 reach end 1101", {4'd0, q}, 8'h0D);
    tick(); chk("R7 end to 0000", {4'd0, q}, 8'h00);
    en = 0;
  endtask

  task automatic t_nocmp;
    start = 4'h1; endv = 4'h5; cmp = 0; do_load(4'h5); en = 1;
    tick(); chk("R8 end ignored", {4'd0, q}, 8'h06);
    en = 0;
  endtask

  task automatic t_rco;
    do_load(4'hF); start = 4'h0; cmp = 0;
    #1 chk("R9 rco low without enable", {7'd0, rco}, 8'd0);
    en = 1; #1 chk("R9 rco at 1111", {7'd0, rco}, 8'd1);
    tick(); chk("R9 rco drops after wrap", {7'd0, rco}, 8'd0);
    en = 0;
  endtask

  task automatic t_cascade;
    start = 4'h0; cmp = 0; load = 0;
    clr = 1; tick(); clr = 0;
    chk("R10 cleared", {q_up, q}, 8'h00);
    en = 1;
    for (int i = 1; i <= 40; i++) begin
      tick();
      chk("R10 cascade", {q_up, q}, 8'(i));
    end
    en = 0;
  endtask

  initial begin
    tick();
    t_reset(); t_clear(); t_load(); t_hold(); t_count();
    t_wrap(); t_end(); t_nocmp(); t_rco(); t_cascade();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      if (done) break;
      @(posedge clk);
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule